// File: doc/BRIEF.md
# CAN Receive Bit Sampler with Self-Test Loop-Back

This block sits between the CAN transceiver pins and the protocol engine. On every sample-point strobe from the bit-timing logic, it works out one received bit value and passes it to the receiver. It can take a single sample, or it can take a majority vote over three samples: the sample at the sample point plus the two samples captured on the two time-quantum ticks just before it. Before any sampling, the receive pin passes through a two-flop synchronizer.

For self test, a loop-back setting routes the transmitter's bit stream straight into the sampler and ignores the receive pin. In this setting the transmit pin is held recessive (logic 1). During the acknowledge slot, which the protocol engine flags, the sampled bit is forced dominant (logic 0), so the node acknowledges its own frame.

The two configuration bits, loop-back and triple sampling, are latched from a write strobe only while the freeze flag is high. A write at any other time leaves the setting unchanged.

Top module: `can_bit_frontend`

## Requirements
- R1: With triple sampling off (cfg_triple = 0), the bit reported one cycle after a sample-point strobe equals the synchronized line value at that strobe. The line value is rx_pin outside loop-back.
- R2: With triple sampling on (cfg_triple = 1), the reported bit is the majority of three values: the line value at the strobe and the line values captured on the two preceding tq_tick pulses. A tick in the same cycle as the strobe does not count as a preceding tick.
- R3: In loop-back (cfg_loop = 1), the line value is tx_bit, and rx_pin has no effect on rx_bit.
- R4: In loop-back, tx_pin is 1 whatever tx_bit is.
- R5: In loop-back, a strobe taken while ack_slot = 1 reports rx_bit = 0. Outside loop-back, ack_slot has no effect.
- R6: cfg_loop and cfg_triple are loaded when cfg_wr = 1 and freeze = 1 together. A cfg_wr with freeze = 0 leaves both unchanged. A write in the same cycle as a strobe takes effect from the next strobe on.
- R7: Outside loop-back, tx_pin follows tx_bit in the same cycle.
- R8: rx_valid is high for exactly the one cycle after each strobe. rx_bit holds its value between strobes.
- R9: After reset, rx_bit = 1 and rx_valid = 0. Loop-back and triple sampling are both off.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| rx_pin | input | 1 | CAN receive pin (asynchronous) |
| tx_bit | input | 1 | Bit from the transmitter |
| tq_tick | input | 1 | One pulse per time quantum |
| sp_strobe | input | 1 | Sample-point strobe |
| ack_slot | input | 1 | High during the acknowledge slot |
| freeze | input | 1 | Freeze mode active |
| cfg_wr | input | 1 | Configuration write strobe |
| cfg_loop_in | input | 1 | Loop-back value to write |
| cfg_triple_in | input | 1 | Triple-sampling value to write |
| rx_bit | output | 1 | Sampled bit to the receiver |
| rx_valid | output | 1 | One-cycle pulse after each sample |
| tx_pin | output | 1 | CAN transmit pin level |

## Verification
Two functions can fall in the same cycle: a configuration write and a sample-point strobe. The bench provokes this by turning triple sampling on in the strobe cycle itself, using a history of 1,1 followed by a 0 at the sample point. The single-sample result is then 0 and the majority result is 1. It judges that strobe to report 0 and the next strobe with the same pattern to report 1. A second overlap, the acknowledge override during a triple-sample vote in loop-back, is judged by requiring 0 even when all three votes are 1.

// File: rtl/can_fe_pkg.sv
package can_fe_pkg;
  localparam int VOTES = 3;
  localparam int HIST_W = VOTES - 1;

  typedef struct packed {
    logic loop;
    logic triple;
  } fe_cfg_t;

  function automatic logic vote3(input logic [VOTES-1:0] s);
    return ($countones(s) > (VOTES / 2));
  endfunction
endpackage

// File: rtl/can_fe_sync.sv
module can_fe_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic d_async,
  output logic d_sync
);
  logic [STAGES-1:0] chain;

  generate
    for (genvar i = 0; i < STAGES; i++) begin : g_stage
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) chain[i] <= 1'b1;
        else if (i == 0) chain[i] <= d_async;
        else chain[i] <= chain[(i == 0) ? 0 : i-1];
      end
    end
  endgenerate

  assign d_sync = chain[STAGES-1];
endmodule

// File: rtl/can_fe_cfg.sv
module can_fe_cfg
  import can_fe_pkg::*;
(
  input  logic    clk,
  input  logic    rst_n,
  input  logic    freeze,
  input  logic    cfg_wr,
  input  logic    loop_in,
  input  logic    triple_in,
  output fe_cfg_t cfg
);
  logic wr_ok;
  assign wr_ok = cfg_wr && freeze;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cfg <= '0;
    else if (wr_ok) cfg <= '{loop: loop_in, triple: triple_in};
  end

  // R6
  cfg_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(cfg_wr && freeze) |=> $stable(cfg));
  // R6
  cfg_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_wr && freeze) |=> (cfg.loop == $past(loop_in)) && (cfg.triple == $past(triple_in)));
endmodule

// File: rtl/can_fe_sampler.sv
module can_fe_sampler
  import can_fe_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic line_in,
  input  logic tq_tick,
  input  logic sp_strobe,
  input  logic triple_en,
  input  logic ack_force,
  output logic rx_bit,
  output logic rx_valid
);
  logic [HIST_W-1:0] hist;
  logic              single_val;
  logic              vote_val;
  logic              next_bit;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) hist <= '1;
    else if (tq_tick) hist <= {hist[HIST_W-2:0], line_in};
  end

  assign single_val = line_in;
  assign vote_val   = vote3({hist, line_in});
  assign next_bit   = ack_force ? 1'b0 : (triple_en ? vote_val : single_val);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rx_bit   <= 1'b1;
      rx_valid <= 1'b0;
    end else begin
      rx_valid <= sp_strobe;
      if (sp_strobe) rx_bit <= next_bit;
    end
  end

  // R8
  valid_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    sp_strobe |=> rx_valid);
  // R8
  bit_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !sp_strobe |=> !rx_valid && $stable(rx_bit));
  // R1
  single_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (sp_strobe && !triple_en && !ack_force) |=> rx_bit == $past(line_in));
  // R2
  vote_agree_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (sp_strobe && triple_en && !ack_force && hist[0] == hist[1]) |=> rx_bit == $past(hist[0]));
endmodule

// File: rtl/can_bit_frontend.sv
module can_bit_frontend
  import can_fe_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic rx_pin,
  input  logic tx_bit,
  input  logic tq_tick,
  input  logic sp_strobe,
  input  logic ack_slot,
  input  logic freeze,
  input  logic cfg_wr,
  input  logic cfg_loop_in,
  input  logic cfg_triple_in,
  output logic rx_bit,
  output logic rx_valid,
  output logic tx_pin
);
  fe_cfg_t cfg;
  logic    rx_sync;
  logic    line_in;
  logic    ack_force;

  can_fe_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst_n(rst_n), .d_async(rx_pin), .d_sync(rx_sync)
  );

  can_fe_cfg u_cfg (
    .clk(clk), .rst_n(rst_n), .freeze(freeze), .cfg_wr(cfg_wr),
    .loop_in(cfg_loop_in), .triple_in(cfg_triple_in), .cfg(cfg)
  );

  assign line_in   = cfg.loop ? tx_bit : rx_sync;
  assign ack_force = cfg.loop && ack_slot;
  assign tx_pin    = cfg.loop ? 1'b1 : tx_bit;

  can_fe_sampler u_smp (
    .clk(clk), .rst_n(rst_n), .line_in(line_in), .tq_tick(tq_tick),
    .sp_strobe(sp_strobe), .triple_en(cfg.triple), .ack_force(ack_force),
    .rx_bit(rx_bit), .rx_valid(rx_valid)
  );

  // R4
  tx_recessive_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cfg.loop |-> tx_pin);
  // R7
  tx_follow_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !cfg.loop |-> tx_pin == tx_bit);
  // R5
  ack_force_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (sp_strobe && cfg.loop && ack_slot) |=> !rx_bit);
  // R3
  loop_path_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (sp_strobe && cfg.loop && !cfg.triple && !ack_slot) |=> rx_bit == $past(tx_bit));
endmodule

// File: tb/can_bit_frontend_tb.sv
module can_bit_frontend_tb_top;
  logic clk = 0, rst_n = 0;
  logic rx_pin = 1, tx_bit = 1, tq_tick = 0, sp_strobe = 0, ack_slot = 0;
  logic freeze = 0, cfg_wr = 0, cfg_loop_in = 0, cfg_triple_in = 0;
  logic rx_bit, rx_valid, tx_pin;
  int total = 0, bad = 0;

  always #5 clk = ~clk;

  can_bit_frontend dut_i (
    .clk(clk), .rst_n(rst_n), .rx_pin(rx_pin), .tx_bit(tx_bit),
    .tq_tick(tq_tick), .sp_strobe(sp_strobe), .ack_slot(ack_slot),
    .freeze(freeze), .cfg_wr(cfg_wr), .cfg_loop_in(cfg_loop_in),
    .cfg_triple_in(cfg_triple_in), .rx_bit(rx_bit), .rx_valid(rx_valid),
    .tx_pin(tx_pin)
  );

  task automatic check(input string req, input logic act, input logic exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%b expected=%b", req, act, exp);
    end
  endtask

  // hold the line value for three edges, pulsing tick/strobe on the last one
  task automatic step(input logic rxv, input logic txv, input logic tick,
                      input logic strb, input logic ack);
    rx_pin = rxv; tx_bit = txv;
    repeat (2) @(negedge clk);
    tq_tick = tick; sp_strobe = strb; ack_slot = ack;
    @(negedge clk);
    tq_tick = 0; sp_strobe = 0; ack_slot = 0;
  endtask

  task automatic write_cfg(input logic frz, input logic lp, input logic tr);
    freeze = frz; cfg_wr = 1; cfg_loop_in = lp; cfg_triple_in = tr;
    @(negedge clk);
    cfg_wr = 0; freeze = 0;
  endtask

  function automatic logic maj(input logic a, input logic b, input logic c);
    return (int'(a) + int'(b) + int'(c)) >= 2;
  endfunction

  initial begin
    repeat (100000) @(posedge clk);
    bad++; total++;
    $display("FAIL watchdog actual=1 expected=0");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    logic prev;
    repeat (2) @(negedge clk);
    // R9 reset state
    check("R9 rx_bit", rx_bit, 1'b1);
    check("R9 rx_valid", rx_valid, 1'b0);
    rst_n = 1;
    @(negedge clk);
    tx_bit = 0; #1;
    check("R9 loop off after reset", tx_pin, 1'b0);

    // R1 single sample sweep (triple off): result is the strobe-time value
    for (int p = 0; p < 8; p++) begin
      step(p[2], 1'b1, 1'b1, 1'b0, 1'b0);
      step(p[1], 1'b1, 1'b1, 1'b0, 1'b0);
      step(p[0], 1'b1, 1'b1, 1'b1, 1'b1); // R5 ack ignored outside loop
      check("R1 single", rx_bit, p[0]);
      check("R8 valid pulse", rx_valid, 1'b1);
    end

    // R7 tx follows tx_bit
    for (int v = 0; v < 2; v++) begin
      tx_bit = v[0]; #1;
      check("R7 tx follow", tx_pin, v[0]);
    end

    // R6 write outside freeze ignored: triple stays off
    write_cfg(1'b0, 1'b1, 1'b1);
    tx_bit = 0; #1;
    check("R6 ignored loop write", tx_pin, 1'b0);
    step(1'b1, 1'b0, 1'b1, 1'b0, 1'b0);
    step(1'b1, 1'b0, 1'b1, 1'b0, 1'b0);
    step(1'b0, 1'b0, 1'b1, 1'b1, 1'b0);
    check("R6 ignored triple write", rx_bit, 1'b0);

    // R6 same-cycle write and strobe: old config applies to this strobe
    step(1'b1, 1'b0, 1'b1, 1'b0, 1'b0);
    step(1'b1, 1'b0, 1'b1, 1'b0, 1'b0);
    rx_pin = 0;
    repeat (2) @(negedge clk);
    tq_tick = 1; sp_strobe = 1;
    freeze = 1; cfg_wr = 1; cfg_loop_in = 0; cfg_triple_in = 1;
    @(negedge clk);
    tq_tick = 0; sp_strobe = 0; freeze = 0; cfg_wr = 0;
    check("R6 same-cycle old config", rx_bit, 1'b0);
    step(1'b1, 1'b0, 1'b1, 1'b0, 1'b0);
    step(1'b1, 1'b0, 1'b1, 1'b0, 1'b0);
    step(1'b0, 1'b0, 1'b1, 1'b1, 1'b0);
    check("R6 new config applied", rx_bit, 1'b1);

    // R2 triple sweep
    for (int p = 0; p < 8; p++) begin
      step(p[2], 1'b1, 1'b1, 1'b0, 1'b0);
      step(p[1], 1'b1, 1'b1, 1'b0, 1'b0);
      step(p[0], 1'b1, 1'b1, 1'b1, 1'b0);
      check("R2 majority", rx_bit, maj(p[2], p[1], p[0]));
    end

    // R8 hold between strobes
    prev = rx_bit;
    step(~prev, 1'b1, 1'b1, 1'b0, 1'b0);
    check("R8 no valid", rx_valid, 1'b0);
    check("R8 bit held", rx_bit, prev);

    // enter loop-back with triple on
    write_cfg(1'b1, 1'b1, 1'b1);
    for (int v = 0; v < 2; v++) begin
      tx_bit = v[0]; #1;
      check("R4 tx recessive", tx_pin, 1'b1);
    end

    // R3 loop sweep, rx_pin driven opposite
    for (int p = 0; p < 8; p++) begin
      step(~p[2], p[2], 1'b1, 1'b0, 1'b0);
      step(~p[1], p[1], 1'b1, 1'b0, 1'b0);
      step(~p[0], p[0], 1'b1, 1'b1, 1'b0);
      check("R3 loop majority", rx_bit, maj(p[2], p[1], p[0]));
    end

    // R5 ack override with all votes recessive
    step(1'b1, 1'b1, 1'b1, 1'b0, 1'b0);
    step(1'b1, 1'b1, 1'b1, 1'b0, 1'b0);
    step(1'b1, 1'b1, 1'b1, 1'b1, 1'b1);
    check("R5 ack dominant", rx_bit, 1'b0);

    // R3 single sample in loop
    write_cfg(1'b1, 1'b1, 1'b0);
    step(1'b0, 1'b1, 1'b0, 1'b1, 1'b0);
    check("R3 loop single", rx_bit, 1'b1);
    step(1'b1, 1'b0, 1'b0, 1'b1, 1'b0);
    check("R3 loop single low", rx_bit, 1'b0);

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule